// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, every clock cycle, which hardware threads of a simultaneous multithreaded core may fetch, and how many instruction slots each chosen thread receives. It keeps three saturating counters per thread: instructions in flight in the front end (decode, rename and issue queues), branches not yet resolved, and data-cache misses still outstanding. The surrounding pipeline reports increment and decrement events for each counter. The block uses them to rank the threads that are ready to fetch.

A two-bit mode input picks the ranking key. Plain rotation ignores the counters. The other three modes favour the thread with the lowest front-end occupancy, the fewest unresolved branches, or the fewest outstanding misses. A pointer that advances every cycle breaks ties, so no ready thread is passed over forever. Two configuration inputs give the number of threads to pick per cycle (X) and the slots per pick (Y). They are clamped so that the total never exceeds the fetch width. The grant vector and the per-thread slot counts are registered.

Top module: `smt_fsel_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it rises, `fetch_grant` and every field of `fetch_slots` are zero. Reset also clears all per-thread counters to zero and sets the rotation pointer to 0.
- R2: The grant and slot values seen after clock edge k are computed from the counter values and pointer held before edge k, and from `thr_ready`, `sel_mode`, `cfg_threads` and `cfg_slots` sampled at edge k. A counter event sampled at edge k therefore affects the grant after edge k+1.
- R3: Only threads whose `thr_ready` bit was set are granted. Exactly min(Xe, number of ready threads) threads are granted, where Xe is the effective thread count from R4.
- R4: Xe is `cfg_threads`, with 0 read as 1 and values above 8 read as 8. The effective slot count Ye is `cfg_slots`, with 0 read as 1, lowered to floor(8/Xe) when Xe*Ye would exceed 8. The sum of all slot fields never exceeds 8.
- R5: `fetch_slots[4t+3:4t]` equals Ye for a granted thread t and is zero for a thread that is not granted.
- R6: In mode 0 (rotation), the ready threads are ordered by distance (t - p) mod 8 from the pointer p. The pointer is 0 on the first edge after reset and advances by one, modulo 8, on every edge.
- R7: In mode 1, threads with fewer front-end instructions pending (`occ_up` adds one, `occ_dn` removes one) are granted first.
- R8: In mode 2, threads with fewer unresolved branches (`br_up` adds one, `br_dn` removes one) are granted first.
- R9: In mode 3, threads with fewer outstanding data-cache misses (`miss_up` adds one, `miss_dn` removes one) are granted first.
- R10: Each counter is 6 bits wide. An increment and a decrement in the same cycle leave it unchanged. A decrement at 0 and an increment at 63 have no effect.
- R11: Among threads with equal keys, the thread with the smaller rotation distance from the pointer (as in R6) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_mode | input | 2 | Ranking key: 0 rotation, 1 occupancy, 2 branches, 3 misses |
| cfg_threads | input | 4 | Requested threads per cycle (X) |
| cfg_slots | input | 4 | Requested slots per thread (Y) |
| thr_ready | input | 8 | Thread may fetch this cycle |
| occ_up | input | 8 | Per thread: one instruction entered the front end |
| occ_dn | input | 8 | Per thread: one instruction left for execution |
| br_up | input | 8 | Per thread: one branch fetched |
| br_dn | input | 8 | Per thread: one branch resolved |
| miss_up | input | 8 | Per thread: one data-cache miss started |
| miss_dn | input | 8 | Per thread: one miss filled |
| fetch_grant | output | 8 | Registered grant vector |
| fetch_slots | output | 32 | Registered slot count, 4 bits per thread |

## Verification
The counters cannot be read directly, so the hardest cases are the two saturation limits. They show up only through a later ranking. The stimulus decrements an empty counter, or pushes a counter past 63 for more than 64 cycles. It then sets a single-pick contest against a thread with a small count. A wrapped counter would reverse the winner. Timing is checked with single-cycle event pulses under the occupancy-style modes, because the registered grant must follow the counter one cycle late.

// File: rtl/smt_fsel_pkg.sv
package smt_fsel_pkg;

    localparam int CNT_W = 6;

    typedef enum logic [1:0] {
        SEL_ROUND  = 2'd0,
        SEL_OCC    = 2'd1,
        SEL_BRANCH = 2'd2,
        SEL_MISS   = 2'd3
    } sel_mode_e;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic inc;
        logic dec;
    } updn_t;

    typedef struct packed {
        updn_t occ;
        updn_t br;
        updn_t miss;
    } thr_ev_t;

    typedef struct packed {
        cnt_t occ;
        cnt_t br;
        cnt_t miss;
    } thr_cnt_t;

    // saturating up/down step; opposing events cancel
    function automatic cnt_t cnt_step(cnt_t v, updn_t e);
        cnt_t r;
        r = v;
        if (e.inc && !e.dec && v != '1)
            r = v + 1'b1;
        else if (e.dec && !e.inc && v != '0)
            r = v - 1'b1;
        return r;
    endfunction

    function automatic int clamp_threads(int req, int nt, int fw);
        int r;
        r = (req == 0) ? 1 : req;
        if (r > nt) r = nt;
        if (r > fw) r = fw;
        return r;
    endfunction

    function automatic int clamp_slots(int req, int xe, int fw);
        int r;
        r = (req == 0) ? 1 : req;
        if (r * xe > fw) r = fw / xe;
        return r;
    endfunction

endpackage

// File: rtl/smt_fsel_cnt.sv
module smt_fsel_cnt
    import smt_fsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  thr_ev_t  ev,
    output thr_cnt_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.occ  <= cnt_step(q.occ,  ev.occ);
            q.br   <= cnt_step(q.br,   ev.br);
            q.miss <= cnt_step(q.miss, ev.miss);
        end
    end

endmodule

// File: rtl/smt_fsel_lim.sv
module smt_fsel_lim
    import smt_fsel_pkg::*;
#(
    parameter int NT      = 8,
    parameter int FETCH_W = 8,
    parameter int CFG_W   = 4,
    parameter int SW      = 4
) (
    input  logic [CFG_W-1:0] cfg_threads,
    input  logic [CFG_W-1:0] cfg_slots,
    output logic [SW-1:0]    x_eff,
    output logic [SW-1:0]    y_eff
);

    int xe;

    always_comb begin
        xe    = clamp_threads(int'(cfg_threads), NT, FETCH_W);
        x_eff = SW'(xe);
        y_eff = SW'(clamp_slots(int'(cfg_slots), xe, FETCH_W));
    end

endmodule

// File: rtl/smt_fsel_rank.sv
module smt_fsel_rank
    import smt_fsel_pkg::*;
#(
    parameter int NT = 8,
    parameter int PW = 3,
    parameter int SW = 4
) (
    input  sel_mode_e            mode,
    input  logic [PW-1:0]        ptr,
    input  logic [NT-1:0]        ready,
    input  thr_cnt_t [NT-1:0]    cnt,
    input  logic [SW-1:0]        x_eff,
    output logic [NT-1:0]        pick
);

    cnt_t          key [NT];
    logic [PW-1:0] pos [NT];

    // ranking key and rotation distance per thread
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            case (mode)
                SEL_OCC:    key[t] = cnt[t].occ;
                SEL_BRANCH: key[t] = cnt[t].br;
                SEL_MISS:   key[t] = cnt[t].miss;
                default:    key[t] = '0;
            endcase
            pos[t] = PW'((t + NT - int'(ptr)) % NT);
        end
    end

    // a thread is picked when fewer than x_eff ready threads beat it
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            int rnk;
            rnk = 0;
            for (int u = 0; u < NT; u++) begin
                if (u != t && ready[u] &&
                    (key[u] < key[t] || (key[u] == key[t] && pos[u] < pos[t])))
                    rnk++;
            end
            pick[t] = ready[t] && (rnk < int'(x_eff));
        end
    end

endmodule

// File: rtl/smt_fsel_top.sv
module smt_fsel_top
    import smt_fsel_pkg::*;
#(
    parameter int NT      = 8,
    parameter int FETCH_W = 8,
    parameter int CFG_W   = 4,
    localparam int SW     = $clog2(FETCH_W + 1),
    localparam int PW     = $clog2(NT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         sel_mode,
    input  logic [CFG_W-1:0]   cfg_threads,
    input  logic [CFG_W-1:0]   cfg_slots,
    input  logic [NT-1:0]      thr_ready,
    input  logic [NT-1:0]      occ_up,
    input  logic [NT-1:0]      occ_dn,
    input  logic [NT-1:0]      br_up,
    input  logic [NT-1:0]      br_dn,
    input  logic [NT-1:0]      miss_up,
    input  logic [NT-1:0]      miss_dn,
    output logic [NT-1:0]      fetch_grant,
    output logic [NT*SW-1:0]   fetch_slots
);

    thr_cnt_t [NT-1:0]  cnt;
    logic [PW-1:0]      ptr_q;
    logic [SW-1:0]      x_eff;
    logic [SW-1:0]      y_eff;
    logic [NT-1:0]      pick;
    logic [NT*SW-1:0]   slots_nx;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        thr_ev_t ev;
        assign ev = {occ_up[t], occ_dn[t], br_up[t], br_dn[t], miss_up[t], miss_dn[t]};
        smt_fsel_cnt u_cnt (
            .clk (clk),
            .rst (rst),
            .ev  (ev),
            .q   (cnt[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (ptr_q == PW'(NT - 1))
            ptr_q <= '0;
        else
            ptr_q <= ptr_q + 1'b1;
    end

    smt_fsel_lim #(
        .NT      (NT),
        .FETCH_W (FETCH_W),
        .CFG_W   (CFG_W),
        .SW      (SW)
    ) u_lim (
        .cfg_threads (cfg_threads),
        .cfg_slots   (cfg_slots),
        .x_eff       (x_eff),
        .y_eff       (y_eff)
    );

    smt_fsel_rank #(
        .NT (NT),
        .PW (PW),
        .SW (SW)
    ) u_rank (
        .mode  (sel_mode_e'(sel_mode)),
        .ptr   (ptr_q),
        .ready (thr_ready),
        .cnt   (cnt),
        .x_eff (x_eff),
        .pick  (pick)
    );

    always_comb begin
        for (int t = 0; t < NT; t++)
            slots_nx[t*SW +: SW] = pick[t] ? y_eff : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_grant <= '0;
            fetch_slots <= '0;
        end else begin
            fetch_grant <= pick;
            fetch_slots <= slots_nx;
        end
    end

endmodule

// File: rtl/smt_fsel_chk.sv
module smt_fsel_chk
    import smt_fsel_pkg::*;
#(
    parameter int NT      = 8,
    parameter int FETCH_W = 8,
    parameter int CFG_W   = 4,
    parameter int SW      = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_threads,
    input logic [NT-1:0]     thr_ready,
    input logic [NT-1:0]     fetch_grant,
    input logic [NT*SW-1:0]  fetch_slots
);

    logic          armed;
    logic [NT-1:0] ready_q;
    int            xcap_q;
    int            slot_sum;
    logic [NT-1:0] slot_nz;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            ready_q <= '0;
            xcap_q  <= 1;
        end else begin
            armed   <= 1'b1;
            ready_q <= thr_ready;
            xcap_q  <= clamp_threads(int'(cfg_threads), NT, FETCH_W);
        end
    end

    always_comb begin
        slot_sum = 0;
        for (int t = 0; t < NT; t++) begin
            slot_sum   = slot_sum + int'(fetch_slots[t*SW +: SW]);
            slot_nz[t] = (fetch_slots[t*SW +: SW] != '0);
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (fetch_grant == '0 && fetch_slots == '0));

    p_ready_only_r3: assert property (@(posedge clk) disable iff (rst)
        armed |-> ((fetch_grant & ~ready_q) == '0));

    p_pick_cap_r3: assert property (@(posedge clk) disable iff (rst)
        armed |-> ($countones(fetch_grant) <= xcap_q));

    p_slot_budget_r4: assert property (@(posedge clk) disable iff (rst)
        slot_sum <= FETCH_W);

    p_slot_match_r5: assert property (@(posedge clk) disable iff (rst)
        slot_nz == fetch_grant);

endmodule

bind smt_fsel_top smt_fsel_chk #(
    .NT      (NT),
    .FETCH_W (FETCH_W),
    .CFG_W   (CFG_W),
    .SW      (SW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_threads (cfg_threads),
    .thr_ready   (thr_ready),
    .fetch_grant (fetch_grant),
    .fetch_slots (fetch_slots)
);

// File: tb/smt_fsel_top_tb.sv
module smt_fsel_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NT  = 8;
    localparam int SW  = 4;
    localparam int CMAX = 63;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    sel_mode = 2'd0;
    logic [3:0]    cfg_threads = 4'd1;
    logic [3:0]    cfg_slots = 4'd1;
    logic [NT-1:0] thr_ready = '0;
    logic [NT-1:0] occ_up = '0, occ_dn = '0, br_up = '0, br_dn = '0, miss_up = '0, miss_dn = '0;
    logic [NT-1:0]    fetch_grant;
    logic [NT*SW-1:0] fetch_slots;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smt_fsel_top u_dut (
        .clk (clk), .rst (rst), .sel_mode (sel_mode),
        .cfg_threads (cfg_threads), .cfg_slots (cfg_slots),
        .thr_ready (thr_ready),
        .occ_up (occ_up), .occ_dn (occ_dn),
        .br_up (br_up), .br_dn (br_dn),
        .miss_up (miss_up), .miss_dn (miss_dn),
        .fetch_grant (fetch_grant), .fetch_slots (fetch_slots)
    );

    // reference model state, built from the requirements
    int m_occ [NT];
    int m_br  [NT];
    int m_miss[NT];
    int m_ptr;

    typedef struct {
        logic [NT-1:0]    g;
        logic [NT*SW-1:0] s;
        string            tag;
    } exp_t;

    exp_t sb[$];

    function automatic int sat(int v, bit up, bit dn);
        if (up && !dn && v < CMAX) return v + 1;
        if (dn && !up && v > 0)    return v - 1;
        return v;
    endfunction

    function automatic exp_t predict(string tag);
        exp_t e;
        int x, y;
        int key[NT];
        x = (cfg_threads == 0) ? 1 : int'(cfg_threads);
        if (x > 8) x = 8;
        y = (cfg_slots == 0) ? 1 : int'(cfg_slots);
        if (x * y > 8) y = 8 / x;
        for (int t = 0; t < NT; t++) begin
            case (sel_mode)
                2'd1:    key[t] = m_occ[t];
                2'd2:    key[t] = m_br[t];
                2'd3:    key[t] = m_miss[t];
                default: key[t] = 0;
            endcase
        end
        e.g = '0;
        e.s = '0;
        for (int t = 0; t < NT; t++) begin
            int better;
            better = 0;
            for (int u = 0; u < NT; u++) begin
                int pu, pt;
                pu = (u - m_ptr + NT) % NT;
                pt = (t - m_ptr + NT) % NT;
                if (u != t && thr_ready[u] &&
                    (key[u] < key[t] || (key[u] == key[t] && pu < pt)))
                    better++;
            end
            if (thr_ready[t] && better < x) begin
                e.g[t] = 1'b1;
                e.s[t*SW +: SW] = SW'(y);
            end
        end
        e.tag = tag;
        return e;
    endfunction

    // driver: inputs already set at a negedge; push expectation, advance model
    task automatic step(string tag);
        sb.push_back(predict(tag));
        @(posedge clk);
        for (int t = 0; t < NT; t++) begin
            m_occ[t]  = sat(m_occ[t],  occ_up[t],  occ_dn[t]);
            m_br[t]   = sat(m_br[t],   br_up[t],   br_dn[t]);
            m_miss[t] = sat(m_miss[t], miss_up[t], miss_dn[t]);
        end
        m_ptr = (m_ptr + 1) % NT;
        @(negedge clk);
        occ_up = '0; occ_dn = '0; br_up = '0; br_dn = '0; miss_up = '0; miss_dn = '0;
    endtask

    // monitor: compare registered outputs just after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (fetch_grant !== e.g || fetch_slots !== e.s) begin
                errors++;
                $display("FAIL %s: grant=%b slots=%h expected grant=%b slots=%h",
                         e.tag, fetch_grant, fetch_slots, e.g, e.s);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        occ_up = '0; occ_dn = '0; br_up = '0; br_dn = '0; miss_up = '0; miss_dn = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (fetch_grant !== '0 || fetch_slots !== '0) begin
            errors++;
            $display("FAIL R1: grant=%b slots=%h expected grant=0 slots=0", fetch_grant, fetch_slots);
        end
        for (int t = 0; t < NT; t++) begin
            m_occ[t] = 0; m_br[t] = 0; m_miss[t] = 0;
        end
        m_ptr = 0;
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();

        // R6 rotation, two threads of four slots, all ready (R2 timing, R5 slots)
        sel_mode = 2'd0; cfg_threads = 4'd2; cfg_slots = 4'd4; thr_ready = 8'hFF;
        repeat (10) step("R6");

        // R3 some threads not ready, wide pick
        cfg_threads = 4'd8; cfg_slots = 4'd1; thr_ready = 8'b1010_0110;
        repeat (4) step("R3");
        cfg_threads = 4'd3; thr_ready = 8'b0001_0000;
        repeat (2) step("R3");
        thr_ready = 8'h00;
        step("R3");

        // R4 clamps
        thr_ready = 8'hFF;
        cfg_threads = 4'd0; cfg_slots = 4'd0; repeat (2) step("R4");
        cfg_threads = 4'd12; cfg_slots = 4'd5; repeat (2) step("R4");
        cfg_threads = 4'd3; cfg_slots = 4'd5; repeat (2) step("R4");
        cfg_threads = 4'd1; cfg_slots = 4'd15; step("R4");

        // R11 equal keys in occupancy mode follow the pointer
        do_reset();
        sel_mode = 2'd1; cfg_threads = 4'd3; cfg_slots = 4'd2; thr_ready = 8'hFF;
        repeat (9) step("R11");

        // R7 occupancy: event pulses then observe one cycle later (R2)
        occ_up = 8'b1111_0000; step("R7");
        occ_up = 8'b0000_1100; step("R7");
        cfg_threads = 4'd2;
        repeat (3) step("R7");
        occ_dn = 8'b1000_0000; occ_up = 8'b0000_0011; step("R7");
        repeat (3) step("R7");

        // R8 branch count
        do_reset();
        sel_mode = 2'd2; cfg_threads = 4'd2; cfg_slots = 4'd3; thr_ready = 8'hFF;
        br_up = 8'b0111_1110; step("R8");
        br_up = 8'b0011_1100; step("R8");
        repeat (3) step("R8");
        br_dn = 8'b0011_0000; step("R8");
        repeat (3) step("R8");

        // R9 miss count, with occupancy changes that must not matter
        do_reset();
        sel_mode = 2'd3; cfg_threads = 4'd1; cfg_slots = 4'd8; thr_ready = 8'hFF;
        miss_up = 8'b1101_1111; occ_up = 8'b0010_0000; step("R9");
        repeat (3) step("R9");
        miss_dn = 8'b0000_0001; step("R9");
        repeat (3) step("R9");

        // R10 simultaneous up and down cancel
        do_reset();
        sel_mode = 2'd1; cfg_threads = 4'd1; cfg_slots = 4'd1; thr_ready = 8'b0000_0011;
        occ_up = 8'b0000_0011; step("R10");
        occ_up = 8'b0000_0001; occ_dn = 8'b0000_0001; step("R10");
        repeat (4) step("R10");

        // R10 decrement at zero ignored: thread 0 stays 0, thread 1 at 1
        do_reset();
        sel_mode = 2'd1; cfg_threads = 4'd1; thr_ready = 8'b0000_0011;
        repeat (3) begin occ_dn = 8'b0000_0001; step("R10"); end
        occ_up = 8'b0000_0010; step("R10");
        repeat (4) step("R10");

        // R10 increment at 63 ignored: thread 0 driven 70 times, thread 2 once
        do_reset();
        sel_mode = 2'd2; cfg_threads = 4'd1; thr_ready = 8'b0000_0101;
        repeat (70) begin br_up = 8'b0000_0001; step("R10"); end
        br_up = 8'b0000_0100; step("R10");
        repeat (4) step("R10");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule